// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a host processor a way into the 16-bit internal control-register space of a serial PHY. The PHY-side space is not mapped directly. The host sees a few 32-bit scratch registers on a simple single-cycle register bus. A value register feeds the PHY's input lines. Four trigger registers each start one operation: capture an address, capture data, read, or write. A result register holds the last word the PHY returned.

To write a PHY register, software does five steps:
1. Load the address into the value register.
2. Fire the capture-address trigger.
3. Load the data into the value register.
4. Fire the capture-data trigger.
5. Fire the write trigger.

To read a PHY register, software loads the address, fires capture-address, fires read, and then picks up the result. Repeating the read is legal and returns the current content again.

Each trigger reads as one while its operation is outstanding and drops back to zero when the operation is done, so software polls it. On the PHY side, each operation drives its own strobe. The strobe stays high until the PHY returns a single acknowledge pulse.

The host bus always accepts a write in the cycle it is presented, so there is no back-pressure there. Flow control lives in the strobe/acknowledge pair only: the PHY may delay its acknowledge for any number of cycles, and the bridge waits.

Top module: `ctlreg_bridge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all strobes are low and every trigger register and the result register read zero.
- R2: The host register map is as follows:
  - 0x0C is the value register (read/write, all 32 bits).
  - 0x10 is the result register (read-only; writes have no effect).
  - 0x14, 0x18, 0x1C and 0x20 are the capture-address, capture-data, read and write triggers.
  - Any other offset reads zero.
- R3: Writing a one to bit 0 of a trigger while the bridge is idle raises that operation's strobe on the next cycle. The trigger then reads 1 in bit 0. At most one strobe is ever high.
- R4: A strobe stays high until a cycle in which the acknowledge input is high. At the next edge, the strobe drops and the trigger reads zero.
- R5: The PHY input lines always carry bits 15:0 of the value register.
- R6: Writing any trigger while an operation is outstanding has no effect. The outstanding operation, its strobe and its trigger are left untouched.
- R7: A trigger write with bit 0 clear starts nothing.
- R8: When a read is acknowledged, the result register takes the PHY's 16-bit data, zero-extended to 32 bits. It holds that value until the next acknowledged read, through acknowledges of other operations.
- R9: Two read operations issued back to back both complete. The second returns the value stored at the captured address.
- R10: An acknowledge that arrives while no operation is outstanding is ignored.
- R11: A full write sequence followed by a read sequence to the same address returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write enable, one cycle per write |
| bus_addr | input | 8 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr, combinational |
| phy_din | output | 16 | Address or data presented to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_ack | input | 1 | One-cycle completion pulse from the PHY |
| phy_rdata | input | 16 | Read data from the PHY, valid with phy_ack |

## Verification
The results fall due at these points:
- A trigger write sampled at edge N shows up as a raised strobe and a set trigger bit right after edge N.
- An acknowledge sampled at edge M drops the strobe, clears the trigger and updates the result register, all right after edge M.
- A value-register write appears on phy_din after its own edge.
- bus_rdata follows bus_addr within the same cycle.

The bench drives inputs just after a rising edge and advances a behavioural model at each rising edge, using the inputs that were stable there. It compares every output against that model at the falling edge, so each result is checked in exactly the cycle it falls due. A PHY register file with random acknowledge delay adds end-to-end write/read checks on top of this.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_DATA  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  localparam int NUM_OPS = 4;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_VALUE  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_RESULT = 8'h10;
  localparam logic [OFS_W-1:0] OFS_TRIG0  = 8'h14;

  // Trigger offsets are spaced one word apart, in operation order.
  function automatic logic [OFS_W-1:0] trig_ofs(input int idx);
    return OFS_TRIG0 + OFS_W'(4 * idx);
  endfunction
endpackage

// File: rtl/ctlreg_host_if.sv
module ctlreg_host_if
  import ctlreg_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int BUS_DW = 32,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              busy,
  input  op_e               cur_op,
  input  logic [PHY_DW-1:0] result,
  output logic [BUS_DW-1:0] value_q,
  output logic              start,
  output op_e               start_op,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int PAD = BUS_DW - PHY_DW;

  logic [NUM_OPS-1:0] trig_hit;
  logic [NUM_OPS-1:0] trig_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (bus_we && bus_addr == BUS_AW'(OFS_VALUE)) begin
      value_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_trig
    assign trig_hit[g]  = bus_we && (bus_addr == BUS_AW'(trig_ofs(g)));
    assign trig_live[g] = busy && (cur_op == op_e'(g));
  end

  always_comb begin
    start    = 1'b0;
    start_op = OP_ADDR;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (trig_hit[i] && bus_wdata[0] && !busy) begin
        start    = 1'b1;
        start_op = op_e'(2'(i));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BUS_AW'(OFS_VALUE)) begin
      bus_rdata = value_q;
    end else if (bus_addr == BUS_AW'(OFS_RESULT)) begin
      bus_rdata = {{PAD{1'b0}}, result};
    end else begin
      for (int i = 0; i < NUM_OPS; i++) begin
        if (bus_addr == BUS_AW'(trig_ofs(i))) begin
          bus_rdata = {{(BUS_DW-1){1'b0}}, trig_live[i]};
        end
      end
    end
  end

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R6
  AST_NO_START_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_wdata[0]) |-> !start); // R7
endmodule

// File: rtl/ctlreg_op_seq.sv
module ctlreg_op_seq
  import ctlreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  op_e                start_op,
  input  logic               phy_ack,
  output logic               busy,
  output op_e                cur_op,
  output logic [NUM_OPS-1:0] strobe,
  output logic               rd_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_op <= OP_ADDR;
    end else if (busy) begin
      if (phy_ack) busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cur_op <= start_op;
    end
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
    assign strobe[g] = busy && (cur_op == op_e'(g));
  end

  assign rd_done = busy && phy_ack && (cur_op == OP_READ);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe)); // R3
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phy_ack) |=> (busy && $stable(strobe))); // R4
  AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phy_ack) |=> (strobe == '0)); // R4
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (strobe == '0)); // R10
endmodule

// File: rtl/ctlreg_rd_hold.sv
module ctlreg_rd_hold #(
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic [PHY_DW-1:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (rd_done) begin
      result <= phy_rdata;
    end
  end

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(result)); // R8
endmodule

// File: rtl/ctlreg_bridge.sv
module ctlreg_bridge
  import ctlreg_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int BUS_DW = 32,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [PHY_DW-1:0] phy_din,
  output logic              phy_cap_addr,
  output logic              phy_cap_data,
  output logic              phy_rd,
  output logic              phy_wr,
  input  logic              phy_ack,
  input  logic [PHY_DW-1:0] phy_rdata
);
  logic               busy;
  op_e                cur_op;
  logic               start;
  op_e                start_op;
  logic [NUM_OPS-1:0] strobe;
  logic               rd_done;
  logic [PHY_DW-1:0]  result;
  logic [BUS_DW-1:0]  value_q;

  ctlreg_host_if #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PHY_DW(PHY_DW)) u_host (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .cur_op(cur_op), .result(result),
    .value_q(value_q), .start(start), .start_op(start_op), .bus_rdata(bus_rdata)
  );

  ctlreg_op_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .phy_ack(phy_ack), .busy(busy), .cur_op(cur_op), .strobe(strobe),
    .rd_done(rd_done)
  );

  ctlreg_rd_hold #(.PHY_DW(PHY_DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .phy_rdata(phy_rdata),
    .result(result)
  );

  assign phy_din      = value_q[PHY_DW-1:0];
  assign phy_cap_addr = strobe[OP_ADDR];
  assign phy_cap_data = strobe[OP_DATA];
  assign phy_rd       = strobe[OP_READ];
  assign phy_wr       = strobe[OP_WRITE];

  AST_PHY_LINES_FOLLOW_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BUS_AW'(OFS_VALUE)) |=> (phy_din == $past(bus_wdata[PHY_DW-1:0]))); // R5
endmodule

// File: tb/sim_ctlreg_bridge.sv
module sim_ctlreg_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] phy_din;
  logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
  logic        a_ack = 1'b0;
  logic        stray_ack = 1'b0;
  logic        phy_ack;
  logic [15:0] phy_rdata = 16'h0;

  assign phy_ack = a_ack | stray_ack;

  ctlreg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phy_din(phy_din),
    .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model of the bridge, advanced at each rising edge.
  logic        m_busy = 1'b0;
  int          m_op = 0;
  logic [31:0] m_value = '0;
  logic [31:0] m_result = '0;

  function automatic logic is_trig(input logic [7:0] a);
    return (a == 8'h14) || (a == 8'h18) || (a == 8'h1C) || (a == 8'h20);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_op = 0; m_value = '0; m_result = '0;
    end else begin
      if (m_busy) begin
        if (phy_ack) begin
          if (m_op == 2) m_result = {16'h0, phy_rdata};
          m_busy = 1'b0;
        end
      end else if (bus_we && is_trig(bus_addr) && bus_wdata[0]) begin
        m_busy = 1'b1;
        m_op = (int'(bus_addr) - 'h14) / 4;
      end
      if (bus_we && bus_addr == 8'h0C) m_value = bus_wdata;
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [7:0] a);
    if (a == 8'h0C) return m_value;
    if (a == 8'h10) return m_result;
    if (is_trig(a)) return {31'h0, m_busy && (m_op == (int'(a) - 'h14) / 4)};
    return 32'h0;
  endfunction

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    check("R3/R4 strobes", {28'h0, phy_wr, phy_rd, phy_cap_data, phy_cap_addr},
          m_busy ? (32'h1 << m_op) : 32'h0);
    check("R5 phy_din", {16'h0, phy_din}, {16'h0, m_value[15:0]});
    check("R2/R8 bus_rdata", bus_rdata, exp_rdata(bus_addr));
  end

  // Behavioural PHY register file with random acknowledge delay.
  logic [15:0] mem [logic [15:0]];
  logic [15:0] p_addr = 16'h0;
  logic [15:0] p_data = 16'h0;
  int          min_delay = 0;

  initial begin
    int cnt;
    cnt = -1;
    forever begin
      @(posedge clk);
      #1;
      if (a_ack) begin
        a_ack = 1'b0;
        cnt = -1;
        phy_rdata = 16'($urandom);
      end else if (phy_cap_addr || phy_cap_data || phy_rd || phy_wr) begin
        if (cnt < 0) cnt = min_delay + $urandom_range(0, 5);
        if (cnt == 0) begin
          if (phy_cap_addr) p_addr = phy_din;
          if (phy_cap_data) p_data = phy_din;
          if (phy_wr) mem[p_addr] = p_data;
          if (phy_rd) phy_rdata = mem.exists(p_addr) ? mem[p_addr] : 16'h0;
          else phy_rdata = 16'($urandom);
          a_ack = 1'b1;
        end else begin
          cnt--;
          phy_rdata = 16'($urandom);
        end
      end else begin
        phy_rdata = 16'($urandom);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 32'($urandom);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_clear(input logic [7:0] a, input string req);
    logic [31:0] v;
    int n;
    n = 0;
    bus_read(a, v);
    while (v != 0 && n < 200) begin
      bus_read(a, v);
      n++;
    end
    check(req, v, 32'h0);
  endtask

  task automatic phy_write(input logic [15:0] a, input logic [15:0] d);
    bus_write(8'h0C, {16'hA5A5, a});
    bus_write(8'h14, 32'h1);
    wait_clear(8'h14, "R4 capture-address trigger clears");
    bus_write(8'h0C, {16'h5A5A, d});
    bus_write(8'h18, 32'h1);
    wait_clear(8'h18, "R4 capture-data trigger clears");
    bus_write(8'h20, 32'h1);
    wait_clear(8'h20, "R4 write trigger clears");
  endtask

  task automatic phy_read(input logic [15:0] a, output logic [31:0] d);
    bus_write(8'h0C, {16'h0, a});
    bus_write(8'h14, 32'h1);
    wait_clear(8'h14, "R4 capture-address trigger clears");
    bus_write(8'h1C, 32'h1);
    wait_clear(8'h1C, "R4 read trigger clears");
    bus_read(8'h10, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    logic [15:0] addrs [5];
    logic [15:0] vals [5];

    addrs = '{16'h102D, 16'h1010, 16'h1006, 16'h1106, 16'h0030};

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 strobes in reset", {28'h0, phy_wr, phy_rd, phy_cap_data, phy_cap_addr}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) begin
      bus_read(8'h14 + 8'(4 * t), v);
      check("R1 trigger zero after reset", v, 32'h0);
    end
    bus_read(8'h10, v);
    check("R1 result zero after reset", v, 32'h0);

    // R2: value register read-back, result not writable, unmapped offset
    bus_write(8'h0C, 32'hDEADBEEF);
    bus_read(8'h0C, v);
    check("R2 value register read-back", v, 32'hDEADBEEF);
    check("R5 phy_din low half", {16'h0, phy_din}, 32'h0000BEEF);
    bus_write(8'h10, 32'h12345678);
    bus_read(8'h10, v);
    check("R2 result register ignores writes", v, 32'h0);
    bus_read(8'h24, v);
    check("R2 unmapped offset reads zero", v, 32'h0);

    // R11: write then read back several addresses
    for (int i = 0; i < 5; i++) begin
      vals[i] = 16'($urandom);
      phy_write(addrs[i], vals[i]);
    end
    for (int i = 0; i < 5; i++) begin
      phy_read(addrs[i], v);
      check("R11 write then read back", v, {16'h0, vals[i]});
    end

    // R9: two reads back to back at the captured address
    phy_read(16'h1010, v);
    bus_write(8'h1C, 32'h1);
    wait_clear(8'h1C, "R9 second read completes");
    bus_read(8'h10, v);
    check("R9 second read value", v, {16'h0, vals[1]});

    // R6: trigger while busy is ignored
    min_delay = 8;
    bus_write(8'h0C, 32'h0000102D);
    bus_write(8'h14, 32'h1);
    bus_write(8'h1C, 32'h1);
    bus_read(8'h1C, v);
    check("R6 read trigger ignored while busy", v, 32'h0);
    bus_read(8'h14, v);
    check("R6 busy trigger still set", v, 32'h1);
    check("R6 read strobe not raised", {31'h0, phy_rd}, 32'h0);
    wait_clear(8'h14, "R6 busy op completes");
    min_delay = 0;

    // R7: bit 0 clear starts nothing
    bus_write(8'h20, 32'hFFFFFFFE);
    bus_read(8'h20, v);
    check("R7 trigger with bit0 clear", v, 32'h0);
    check("R7 no write strobe", {31'h0, phy_wr}, 32'h0);

    // R8: result holds through non-read operations
    phy_read(16'h0030, keep);
    check("R8 read result", keep, {16'h0, vals[4]});
    phy_write(16'h0030, 16'hBEEF);
    bus_read(8'h10, v);
    check("R8 result held through write op", v, keep);

    // R10: stray acknowledge while idle
    @(posedge clk); #1;
    stray_ack = 1'b1;
    @(posedge clk); #1;
    stray_ack = 1'b0;
    bus_read(8'h10, v);
    check("R10 result unchanged by stray ack", v, keep);
    bus_read(8'h1C, v);
    check("R10 no trigger set by stray ack", v, 32'h0);

    phy_read(16'h0030, v);
    check("R11 overwrite visible", v, 32'h0000BEEF);

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule